// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle it can accept one opcode byte together with the accumulator value and a second operand byte. The surrounding datapath supplies that second operand: a register value or an immediate byte for the two-operand forms, and the value of the addressed register for increment and decrement. The block works out which operation the opcode names and computes the 8-bit result. It also computes four condition flags (zero, subtract, half-carry, carry) and keeps them in an internal flag byte. The carry bit of that flag byte is the carry-in for the add-with-carry and subtract-with-carry forms.

Results and flags appear one clock after an accepted opcode. A small sequencer with two states, `ST_IDLE` and `ST_RESULT`, marks that cycle. In `ST_IDLE` nothing is presented. An accepted opcode moves it to `ST_RESULT` (transition *accept*). In `ST_RESULT` a further accepted opcode keeps it there (transition *accept-again*). A cycle with no accepted opcode returns it to `ST_IDLE` (transition *drain*). Reset forces `ST_IDLE` and clears the flag byte.

Opcodes outside the arithmetic and logic groups are not accepted. They leave the flag byte unchanged and produce no output strobes.

Top module: `alu8_core`

## Requirements
- R1: Opcode `10 ooo rrr` (any rrr) and `11 ooo 110` select the operation from ooo: 000 add, 001 add-with-carry, 010 subtract, 011 subtract-with-carry, 100 AND, 101 XOR, 110 OR, 111 compare. The operand for both forms is `opnd_in`. Any other opcode with `op_valid` high gives no `flags_we` and no `res_valid`, and leaves `flags_q` unchanged.
- R2: Add gives `acc_in + opnd_in` mod 256. C=1 on unsigned overflow, N=0, H=1 when the two low nibbles sum above 0xF.
- R3: Add-with-carry adds `opnd_in` plus the stored carry. C is set when the 9-bit total exceeds 255. H is the add nibble rule applied to `acc_in` and the 8-bit wrapped value `opnd_in + carry`.
- R4: Subtract and subtract-with-carry give `acc_in - opnd_in - cin` mod 256, where cin is the stored carry for the with-carry form and 0 otherwise. C=1 on unsigned borrow (`acc_in < opnd_in + cin`) and N=1. Let b' be `(opnd_in + cin)` mod 256. H=1 when bit 4 of `((acc_in & 0x1F) - (b' & 0x0F))` differs from bit 4 of `acc_in`.
- R5: Compare sets the flags exactly as subtract does. It presents `acc_in` on `res_data` and keeps `res_valid` low, so nothing is written back; `flags_we` still pulses.
- R6: AND gives `acc_in & opnd_in` with C=0, N=0, H=1.
- R7: OR and XOR give `acc_in | opnd_in` and `acc_in ^ opnd_in` with C=0, H=0, N=0.
- R8: For every accepted operation Z=1 exactly when the 8-bit computed value (the difference, for compare) is zero.
- R9: Opcodes `00 rrr 100` and `00 rrr 101` increment and decrement `opnd_in` by one. The half-carry rules are those of add and subtract. N is 0 for increment and 1 for decrement. C is set on the 0xFF to 0x00 or 0x00 to 0xFF wrap. `res_dest` equals rrr.
- R10: `flags_q` packs Z at bit 7, N at bit 6, H at bit 5 and C at bit 4, with bits 3..0 always 0. It changes only in cycles where `flags_we` is high.
- R11: An opcode accepted at a clock edge produces `flags_we` high, and `res_valid` high when it writes back, during the following cycle only. Two-operand forms drive `res_dest` = 7.
- R12: During and immediately after reset, `flags_q` = 0x00 and `res_valid` = `flags_we` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode strobe for this cycle |
| opcode | input | 8 | Instruction byte |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand, or the addressed register for increment/decrement |
| res_valid | output | 1 | Result is to be written to `res_dest` |
| res_data | output | 8 | Result byte (accumulator unchanged for compare) |
| res_dest | output | 3 | Destination register index (7 = accumulator) |
| flags_we | output | 1 | Flag byte was updated by the previous opcode |
| flags_q | output | 8 | Stored flag byte Z N H C 0 0 0 0 |

## Verification
Every two-operand opcode is issued in register form, with each rrr value, and in immediate form. The operands come from a grid that mixes nibble and byte boundaries (0x00, 0x01, 0x0F, 0x10, 0x7F, 0x80, 0xFE, 0xFF) with spread values, so half-carry, full carry, borrow and zero are each driven both high and low. Each pair is run once with the stored carry set and once with it clear. The with-carry forms are thereby told apart from the plain forms, and the wrapped operand-plus-carry half-carry case is exercised at 0xFF and 0x0F. Increment and decrement sweep the same boundary values at every rrr to separate the wrap from the nibble carry. Opcodes outside the groups, and idle cycles, are interleaved to show that the flag byte holds.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        K_ADD, K_ADC, K_SUB, K_SBC, K_AND, K_XOR, K_OR, K_CP,
        K_INC, K_DEC, K_NONE
    } alu_kind_t;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_RESULT
    } seq_state_t;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flag4_t;

    localparam logic [2:0] ACC_CODE = 3'd7;

    function automatic alu_kind_t op_field_kind(input logic [2:0] ooo);
        alu_kind_t k;
        unique case (ooo)
            3'd0: k = K_ADD;
            3'd1: k = K_ADC;
            3'd2: k = K_SUB;
            3'd3: k = K_SBC;
            3'd4: k = K_AND;
            3'd5: k = K_XOR;
            3'd6: k = K_OR;
            default: k = K_CP;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [7:0] opcode,
    output alu_kind_t  kind,
    output logic [2:0] dest,
    output logic       writes_back
);
    always_comb begin
        kind        = K_NONE;
        dest        = ACC_CODE;
        writes_back = 1'b0;
        unique case (opcode[7:6])
            2'b10: begin
                kind        = op_field_kind(opcode[5:3]);
                writes_back = (opcode[5:3] != 3'b111);
            end
            2'b11: begin
                if (opcode[2:0] == 3'b110) begin
                    kind        = op_field_kind(opcode[5:3]);
                    writes_back = (opcode[5:3] != 3'b111);
                end
            end
            2'b00: begin
                if (opcode[2:0] == 3'b100) begin
                    kind        = K_INC;
                    dest        = opcode[5:3];
                    writes_back = 1'b1;
                end else if (opcode[2:0] == 3'b101) begin
                    kind        = K_DEC;
                    dest        = opcode[5:3];
                    writes_back = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              cy,
    output logic              hc
);
    localparam int unsigned NIB_W = DATA_W / 2;

    logic [DATA_W:0]   full;
    logic [DATA_W-1:0] b_adj;
    logic [NIB_W:0]    nib_sum;
    logic [NIB_W:0]    nib_dif;
    logic [DATA_W:0]   cin_w;

    always_comb begin
        cin_w   = {{DATA_W{1'b0}}, cin};
        b_adj   = b + cin_w[DATA_W-1:0];
        nib_sum = {1'b0, a[NIB_W-1:0]} + {1'b0, b_adj[NIB_W-1:0]};
        nib_dif = a[NIB_W:0] - {1'b0, b_adj[NIB_W-1:0]};
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - cin_w;
            hc   = nib_dif[NIB_W] ^ a[NIB_W];
        end else begin
            full = {1'b0, a} + {1'b0, b} + cin_w;
            hc   = nib_sum[NIB_W];
        end
        res = full[DATA_W-1:0];
        cy  = full[DATA_W];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [1:0]        sel,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        unique case (sel)
            2'd0:    res = a & b;
            2'd1:    res = a ^ b;
            default: res = a | b;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [2:0]        res_dest,
    output logic              flags_we,
    output logic [DATA_W-1:0] flags_q
);
    localparam int unsigned LOW_W = DATA_W - 4;

    seq_state_t  state_q, state_d;
    alu_kind_t   kind;
    logic [2:0]  dec_dest;
    logic        dec_wb;
    logic        accept;
    logic        is_step;
    logic        is_logic;
    logic        sub_sel;
    logic        cin_sel;
    logic [DATA_W-1:0] a_sel, b_sel;
    logic [DATA_W-1:0] as_res, lg_res;
    logic        as_cy, as_hc;
    logic [1:0]  lg_sel;
    logic [DATA_W-1:0] res_d;
    flag4_t      flg_d, flg_q;
    logic        wb_q;

    alu8_decode u_dec (
        .opcode      (opcode),
        .kind        (kind),
        .dest        (dec_dest),
        .writes_back (dec_wb)
    );

    always_comb begin
        accept   = op_valid && (kind != K_NONE);
        is_step  = (kind == K_INC) || (kind == K_DEC);
        is_logic = (kind == K_AND) || (kind == K_XOR) || (kind == K_OR);
        sub_sel  = (kind == K_SUB) || (kind == K_SBC) || (kind == K_CP) || (kind == K_DEC);
        cin_sel  = ((kind == K_ADC) || (kind == K_SBC)) && flg_q.c;
        a_sel    = is_step ? opnd_in : acc_in;
        b_sel    = is_step ? {{(DATA_W-1){1'b0}}, 1'b1} : opnd_in;
        unique case (kind)
            K_AND:   lg_sel = 2'd0;
            K_XOR:   lg_sel = 2'd1;
            default: lg_sel = 2'd2;
        endcase
    end

    alu8_addsub #(.DATA_W(DATA_W)) u_as (
        .a   (a_sel),
        .b   (b_sel),
        .cin (cin_sel),
        .sub (sub_sel),
        .res (as_res),
        .cy  (as_cy),
        .hc  (as_hc)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_lg (
        .a   (acc_in),
        .b   (opnd_in),
        .sel (lg_sel),
        .res (lg_res)
    );

    always_comb begin
        if (is_logic) begin
            res_d   = lg_res;
            flg_d.z = (lg_res == '0);
            flg_d.n = 1'b0;
            flg_d.h = (kind == K_AND);
            flg_d.c = 1'b0;
        end else begin
            res_d   = (kind == K_CP) ? acc_in : as_res;
            flg_d.z = (as_res == '0);
            flg_d.n = sub_sel;
            flg_d.h = as_hc;
            flg_d.c = as_cy;
        end
    end

    // sequencer next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = accept ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = accept ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q    <= '0;
            res_data <= '0;
            res_dest <= ACC_CODE;
            wb_q     <= 1'b0;
        end else if (accept) begin
            flg_q    <= flg_d;
            res_data <= res_d;
            res_dest <= dec_dest;
            wb_q     <= dec_wb;
        end
    end

    // outputs
    always_comb begin
        res_valid = 1'b0;
        flags_we  = 1'b0;
        unique case (state_q)
            ST_RESULT: begin
                res_valid = wb_q;
                flags_we  = 1'b1;
            end
            default: ;
        endcase
        flags_q = {flg_q.z, flg_q.n, flg_q.h, flg_q.c, {LOW_W{1'b0}}};
    end
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [7:0]        opcode,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic              flags_we,
    input logic [DATA_W-1:0] flags_q
);
    AST_REG_FORM_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[7:6] == 2'b10) |=> flags_we); // R1
    AST_ADD_CLEARS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[7:4] == 4'b1000) |=> !flags_q[DATA_W-2]); // R2
    AST_SUB_SETS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[7:4] == 4'b1001) |=> flags_q[DATA_W-2]); // R4
    AST_CP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[7:3] == 5'b10111) |=> (!res_valid && flags_we && flags_q[DATA_W-2])); // R5
    AST_AND_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[7:3] == 5'b10100) |=> (flags_q[DATA_W-3] && !flags_q[DATA_W-4] && !flags_q[DATA_W-2])); // R6
    AST_ORXOR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode[7:3] == 5'b10101 || opcode[7:3] == 5'b10110)) |=> (flags_q[DATA_W-1:DATA_W-4] & 4'b0111) == 4'b0000); // R7
    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (flags_q[DATA_W-1] == (res_data == '0))); // R8
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_we |-> (flags_q == $past(flags_q))); // R10
    AST_QUIET_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!flags_we && !res_valid)); // R11
endmodule

bind alu8_core alu8_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .opcode    (opcode),
    .res_valid (res_valid),
    .res_data  (res_data),
    .flags_we  (flags_we),
    .flags_q   (flags_q)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [7:0] opcode, acc_in, opnd_in;
    logic       res_valid, flags_we;
    logic [7:0] res_data, flags_q;
    logic [2:0] res_dest;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;
    logic [7:0] m_flags = 8'h00;

    always #10 clk = ~clk;

    alu8_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .acc_in(acc_in), .opnd_in(opnd_in), .res_valid(res_valid),
        .res_data(res_data), .res_dest(res_dest), .flags_we(flags_we),
        .flags_q(flags_q)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pick(input int i);
        case (i)
            0: return 8'h00; 1: return 8'h01; 2: return 8'h0F; 3: return 8'h10;
            4: return 8'h7F; 5: return 8'h80; 6: return 8'hFE; 7: return 8'hFF;
            default: return 8'((i * 37 + 11) % 256);
        endcase
    endfunction

    // behavioural reference: kind 0..7 ooo, 8 inc, 9 dec, 10 none
    task automatic issue(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b);
        int kind, ai, bi, ci, s, r, bb, z, n, h, c, dst;
        bit ev, ewb;
        string tag;
        logic [7:0] ef, edata;
        ai = int'(a); bi = int'(b);
        kind = 10; dst = 7;
        if (op[7:6] == 2'b10 || (op[7:6] == 2'b11 && op[2:0] == 3'b110)) kind = int'(op[5:3]);
        else if (op[7:6] == 2'b00 && op[2:0] == 3'b100) begin kind = 8; dst = int'(op[5:3]); end
        else if (op[7:6] == 2'b00 && op[2:0] == 3'b101) begin kind = 9; dst = int'(op[5:3]); end
        ci = (kind == 1 || kind == 3) ? int'(m_flags[4]) : 0;
        r = 0; z = 0; n = 0; h = 0; c = 0;
        case (kind)
            0, 1, 8: begin
                if (kind == 8) begin ai = int'(b); bi = 1; end
                s = ai + bi + ci; r = s % 256; c = (s > 255) ? 1 : 0;
                bb = (bi + ci) % 256; h = ((ai % 16) + (bb % 16) > 15) ? 1 : 0; n = 0;
            end
            2, 3, 7, 9: begin
                if (kind == 9) begin ai = int'(b); bi = 1; end
                s = ai - bi - ci; r = (s + 512) % 256; c = (s < 0) ? 1 : 0;
                bb = (bi + ci) % 256;
                h = ((((ai % 32) - (bb % 16) + 32) % 32) / 16 != (ai / 16) % 2) ? 1 : 0; n = 1;
            end
            4: begin r = ai & bi; h = 1; end
            5: r = ai ^ bi;
            6: r = ai | bi;
            default: ;
        endcase
        z = (r == 0) ? 1 : 0;
        ev  = (kind != 10);
        ewb = ev && (kind != 7);
        edata = (kind == 7) ? a : 8'(r);
        ef = ev ? 8'({z[0], n[0], h[0], c[0], 4'b0000}) : m_flags;
        case (kind)
            0: tag = "R2"; 1: tag = "R3"; 2, 3: tag = "R4"; 7: tag = "R5";
            4: tag = "R6"; 5, 6: tag = "R7"; 8, 9: tag = "R9"; default: tag = "R1";
        endcase
        op_valid = 1'b1; opcode = op; acc_in = a; opnd_in = b;
        @(negedge clk);
        op_valid = 1'b0;
        chk(flags_we == ev, ev ? "R11" : "R1", "flags_we", int'(flags_we), int'(ev));
        chk(res_valid == ewb, (kind == 7) ? "R5" : (ev ? "R11" : "R1"), "res_valid", int'(res_valid), int'(ewb));
        chk(flags_q[7] == ef[7], ev ? "R8" : "R1", "zero", int'(flags_q[7]), int'(ef[7]));
        chk(flags_q[6:4] == ef[6:4], tag, "nhc", int'(flags_q[6:4]), int'(ef[6:4]));
        chk(flags_q[3:0] == 4'h0, "R10", "low nibble", int'(flags_q[3:0]), 0);
        if (ev) chk(res_data == edata, tag, "res_data", int'(res_data), int'(edata));
        if (ewb) chk(res_dest == 3'(dst), (kind >= 8) ? "R9" : "R11", "res_dest", int'(res_dest), dst);
        m_flags = ef;
    endtask

    task automatic set_carry(input bit v);
        if (v) issue(8'hD6, 8'h00, 8'h01);
        else   issue(8'hF6, 8'h00, 8'h00);
    endtask

    task automatic idle_cycle();
        op_valid = 1'b0;
        @(negedge clk);
        chk(!flags_we && !res_valid, "R11", "idle strobes", int'({flags_we, res_valid}), 0);
        chk(flags_q == m_flags, "R10", "idle hold", int'(flags_q), int'(m_flags));
    endtask

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; opcode = 8'h00; acc_in = 8'h00; opnd_in = 8'h00;
        repeat (3) @(negedge clk);
        chk(flags_q == 8'h00, "R12", "reset flags", int'(flags_q), 0);
        chk(!flags_we && !res_valid, "R12", "reset strobes", int'({flags_we, res_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(flags_q == 8'h00 && !flags_we && !res_valid, "R12", "after reset", int'(flags_q), 0);
        for (int ooo = 0; ooo < 8; ooo++) begin
            for (int ai = 0; ai < 18; ai++) begin
                for (int bi = 0; bi < 18; bi++) begin
                    for (int cv = 0; cv < 2; cv++) begin
                        set_carry(cv[0]);
                        issue(8'(8'hC6 | (ooo << 3)), pick(ai), pick(bi));
                        set_carry(cv[0]);
                        issue(8'(8'h80 | (ooo << 3) | ((ai + bi) % 8)), pick(ai), pick(bi));
                    end
                end
                issue(8'hC3, pick(ai), 8'h5A);
                issue(8'(8'h76 - ai % 2), pick(ai), 8'h00);
                idle_cycle();
            end
        end
        for (int rr = 0; rr < 8; rr++) begin
            for (int vi = 0; vi < 18; vi++) begin
                for (int cv = 0; cv < 2; cv++) begin
                    set_carry(cv[0]);
                    issue(8'(8'h04 | (rr << 3)), 8'h33, pick(vi));
                    set_carry(cv[0]);
                    issue(8'(8'h05 | (rr << 3)), 8'h33, pick(vi));
                end
            end
        end
        issue(8'h00, 8'h12, 8'h34);
        idle_cycle();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R11 watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule